// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Gate Controller

This block sits between a power-mode request and the clock gating cells of a device. It owns two clock enables: one for the free-running core clock and one for the bus clock. For each of three low-power modes (sleep, stop, standby) it decides whether those clocks run, which source feeds them, and whether the power domain is asked to switch off. A three-bit debug control word keeps each mode debuggable. Each bit stands for one mode and keeps the clocks alive where a normal low-power entry would gate them or drop power.

The block holds a one-bit clock configuration that says whether the configured system clock (PLL and crystal path) or the internal RC oscillator is in use. Sleep leaves this configuration as it is. Leaving stop or standby returns it to the RC oscillator. Leaving standby also raises a one-cycle system reset request and sets a resumed-from-standby flag, which stays set until it is cleared.

Top module: `pmgate_top`

## Requirements
- R1: During and after reset: mode is run, fclk_en=1, hclk_en=1, src_rc=1, sys_clk_en=0, pd_req=0, rst_req=0, stby_resumed=0.
- R2: mode_req encodes 0=run, 1=sleep, 2=stop, 3=standby. In run, a non-zero mode_req is taken at the next rising edge, and all outputs for the new mode appear at that same edge. mode_req has no effect while a low-power mode is active.
- R3: In sleep with dbg_ctl[0]=0, fclk_en=1 and hclk_en=0. With dbg_ctl[0]=1, both enables are 1. src_rc keeps its run value.
- R4: In stop with dbg_ctl[1]=0, both enables are 0. With dbg_ctl[1]=1, both are 1 and src_rc=1.
- R5: In standby with dbg_ctl[2]=0, pd_req=1 and both enables are 0. With dbg_ctl[2]=1, pd_req=0, both enables are 1 and src_rc=1.
- R6: The override bit is captured at mode entry. Changes to dbg_ctl while in a low-power mode have no effect.
- R7: wake in a low-power mode returns to run at the next rising edge, with fclk_en=hclk_en=1 and pd_req=0. wake while in run has no effect.
- R8: cfg_wr while in run loads cfg_sys into the configuration, giving sys_clk_en=cfg_sys and src_rc=!cfg_sys. cfg_wr is ignored in low-power modes. Leaving sleep keeps the configuration.
- R9: Leaving stop or standby clears the configuration (sys_clk_en=0, src_rc=1).
- R10: Leaving standby gives rst_req=1 for exactly one cycle and sets stby_resumed. flag_clr clears stby_resumed, but a set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested mode (0 run, 1 sleep, 2 stop, 3 standby) |
| wake | input | 1 | Wake event |
| dbg_ctl | input | 3 | Per-mode debug override bits (sleep, stop, standby) |
| cfg_wr | input | 1 | Load clock configuration strobe |
| cfg_sys | input | 1 | 1 selects the configured system clock |
| flag_clr | input | 1 | Clears the resumed-from-standby flag |
| fclk_en | output | 1 | Core clock enable, registered |
| hclk_en | output | 1 | Bus clock enable, registered |
| src_rc | output | 1 | 1 = internal RC oscillator feeds the clocks |
| sys_clk_en | output | 1 | PLL and crystal enable |
| pd_req | output | 1 | Power-down request |
| rst_req | output | 1 | One-cycle system reset request |
| stby_resumed | output | 1 | Device resumed from standby |

## Verification
Two events can land in the same edge. The first is a standby exit that sets the resumed flag while a software clear of that flag arrives. The second is a wake in stop arriving together with a configuration write. The bench raises wake together with flag_clr, and wake together with cfg_wr, in the very cycle of the exit. A behavioural model applies set-over-clear and exit-clears-configuration, and every output is compared against it on each clock. A wake held in run together with a new mode request shows that the request wins.

// File: rtl/pmgate_pkg.sv
package pmgate_pkg;
   typedef enum logic [1:0] {
      M_RUN   = 2'd0,
      M_SLEEP = 2'd1,
      M_STOP  = 2'd2,
      M_STBY  = 2'd3
   } pm_mode_e;
endpackage

// File: rtl/pmgate_mode_fsm.sv
module pmgate_mode_fsm
   import pmgate_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter int DBG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_req,
   input  logic              wake,
   input  logic [DBG_W-1:0]  dbg_ctl,
   output pm_mode_e          mode_q,
   output pm_mode_e          mode_nxt,
   output logic              ovr_nxt,
   output logic              exit_stop,
   output logic              exit_stby
);
   localparam int N_LP = (1 << MODE_W) - 1;

   if (MODE_W != 2) begin : g_bad_mode_w
      $error("pmgate_mode_fsm: MODE_W must be 2");
   end
   if (DBG_W != N_LP) begin : g_bad_dbg_w
      $error("pmgate_mode_fsm: DBG_W must equal the number of low-power modes");
   end

   logic             ovr_q;
   logic [DBG_W-1:0] ovr_pick;
   logic             entering;

   // one override candidate per low-power mode
   for (genvar g = 0; g < DBG_W; g++) begin : g_pick
      assign ovr_pick[g] = (mode_req == MODE_W'(g + 1)) & dbg_ctl[g];
   end

   always_comb begin
      mode_nxt = mode_q;
      if (mode_q != M_RUN) begin
         if (wake) mode_nxt = M_RUN;
      end else begin
         mode_nxt = pm_mode_e'(mode_req);
      end
      entering  = (mode_q == M_RUN) && (mode_nxt != M_RUN);
      ovr_nxt   = entering ? (|ovr_pick) : ((mode_nxt == M_RUN) ? 1'b0 : ovr_q);
      exit_stop = (mode_q == M_STOP) && (mode_nxt == M_RUN);
      exit_stby = (mode_q == M_STBY) && (mode_nxt == M_RUN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_RUN;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= mode_nxt;
         ovr_q  <= ovr_nxt;
      end
   end

   // R7
   wake_returns_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != M_RUN && wake) |=> (mode_q == M_RUN));

   // R6
   ovr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != M_RUN && !wake) |=> $stable(ovr_q));
endmodule

// File: rtl/pmgate_cfg_status.sv
module pmgate_cfg_status (
   input  logic clk,
   input  logic rst_n,
   input  logic in_run,
   input  logic cfg_wr,
   input  logic cfg_sys,
   input  logic exit_stop,
   input  logic exit_stby,
   input  logic flag_clr,
   output logic sys_cfg_q,
   output logic sys_cfg_nxt,
   output logic rst_req,
   output logic stby_resumed
);
   always_comb begin
      if (exit_stop || exit_stby)  sys_cfg_nxt = 1'b0;
      else if (in_run && cfg_wr)   sys_cfg_nxt = cfg_sys;
      else                         sys_cfg_nxt = sys_cfg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_cfg_q    <= 1'b0;
         rst_req      <= 1'b0;
         stby_resumed <= 1'b0;
      end else begin
         sys_cfg_q <= sys_cfg_nxt;
         rst_req   <= exit_stby;
         if (exit_stby)     stby_resumed <= 1'b1;
         else if (flag_clr) stby_resumed <= 1'b0;
      end
   end

   // R10
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R10
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_stby && flag_clr) |=> stby_resumed);
endmodule

// File: rtl/pmgate_clk_policy.sv
module pmgate_clk_policy
   import pmgate_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pm_mode_e mode_nxt,
   input  logic     ovr_nxt,
   input  logic     sys_cfg_nxt,
   output logic     fclk_en,
   output logic     hclk_en,
   output logic     src_rc,
   output logic     pd_req
);
   logic f_d, h_d, s_d, p_d;

   always_comb begin
      f_d = 1'b1;
      h_d = 1'b1;
      s_d = !sys_cfg_nxt;
      p_d = 1'b0;
      unique case (mode_nxt)
         M_RUN:   ;
         M_SLEEP: h_d = ovr_nxt;
         M_STOP:  begin f_d = ovr_nxt; h_d = ovr_nxt; s_d = 1'b1; end
         M_STBY:  begin f_d = ovr_nxt; h_d = ovr_nxt; s_d = 1'b1; p_d = !ovr_nxt; end
         default: ;
      endcase
   end

   // registered enables: no combinational path reaches the gate cells
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclk_en <= 1'b1;
         hclk_en <= 1'b1;
         src_rc  <= 1'b1;
         pd_req  <= 1'b0;
      end else begin
         fclk_en <= f_d;
         hclk_en <= h_d;
         src_rc  <= s_d;
         pd_req  <= p_d;
      end
   end

   // R5
   pd_gates_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |-> (!fclk_en && !hclk_en));

   // R3
   bus_never_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hclk_en |-> fclk_en);
endmodule

// File: rtl/pmgate_top.sv
module pmgate_top
   import pmgate_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter int DBG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_req,
   input  logic              wake,
   input  logic [DBG_W-1:0]  dbg_ctl,
   input  logic              cfg_wr,
   input  logic              cfg_sys,
   input  logic              flag_clr,
   output logic              fclk_en,
   output logic              hclk_en,
   output logic              src_rc,
   output logic              sys_clk_en,
   output logic              pd_req,
   output logic              rst_req,
   output logic              stby_resumed
);
   pm_mode_e mode_q, mode_nxt;
   logic     ovr_nxt, exit_stop, exit_stby, sys_cfg_q, sys_cfg_nxt;

   pmgate_mode_fsm #(.MODE_W(MODE_W), .DBG_W(DBG_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wake(wake),
      .dbg_ctl(dbg_ctl), .mode_q(mode_q), .mode_nxt(mode_nxt),
      .ovr_nxt(ovr_nxt), .exit_stop(exit_stop), .exit_stby(exit_stby));

   pmgate_cfg_status u_cfg (
      .clk(clk), .rst_n(rst_n), .in_run(mode_q == M_RUN), .cfg_wr(cfg_wr),
      .cfg_sys(cfg_sys), .exit_stop(exit_stop), .exit_stby(exit_stby),
      .flag_clr(flag_clr), .sys_cfg_q(sys_cfg_q), .sys_cfg_nxt(sys_cfg_nxt),
      .rst_req(rst_req), .stby_resumed(stby_resumed));

   pmgate_clk_policy u_pol (
      .clk(clk), .rst_n(rst_n), .mode_nxt(mode_nxt), .ovr_nxt(ovr_nxt),
      .sys_cfg_nxt(sys_cfg_nxt), .fclk_en(fclk_en), .hclk_en(hclk_en),
      .src_rc(src_rc), .pd_req(pd_req));

   assign sys_clk_en = sys_cfg_q;

   // R9
   deep_exit_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_stop || exit_stby) |=> (src_rc && !sys_clk_en));

   // R7
   run_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_RUN) |-> (fclk_en && hclk_en && !pd_req));
endmodule

// File: tb/pmgate_top_test.sv
module pmgate_top_test;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [1:0] mode_req = 0;
   logic       wake = 0;
   logic [2:0] dbg_ctl = 0;
   logic       cfg_wr = 0, cfg_sys = 0, flag_clr = 0;
   logic       fclk_en, hclk_en, src_rc, sys_clk_en, pd_req, rst_req, stby_resumed;

   int checks = 0, failures = 0;
   string req = "R1";
   bit done = 0;

   // behavioural reference state
   int  m_mode = 0;
   bit  m_ovr = 0, m_cfg = 0, m_flag = 0, m_rst = 0;
   bit  e_f = 1, e_h = 1, e_src = 1, e_pd = 0;

   always #2.5 clk = ~clk;

   pmgate_top uut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wake(wake),
      .dbg_ctl(dbg_ctl), .cfg_wr(cfg_wr), .cfg_sys(cfg_sys), .flag_clr(flag_clr),
      .fclk_en(fclk_en), .hclk_en(hclk_en), .src_rc(src_rc),
      .sys_clk_en(sys_clk_en), .pd_req(pd_req), .rst_req(rst_req),
      .stby_resumed(stby_resumed));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_ovr = 0; m_cfg = 0; m_flag = 0; m_rst = 0;
         e_f = 1; e_h = 1; e_src = 1; e_pd = 0;
      end else begin
         int nm;
         bit leave_deep;
         nm = (m_mode != 0) ? (wake ? 0 : m_mode) : int'(mode_req);
         if (m_mode == 0 && nm != 0) m_ovr = dbg_ctl[nm-1];
         else if (nm == 0)           m_ovr = 0;
         leave_deep = (m_mode >= 2) && (nm == 0);
         if (leave_deep)                 m_cfg = 0;
         else if (m_mode == 0 && cfg_wr) m_cfg = cfg_sys;
         m_rst = (m_mode == 3) && (nm == 0);
         if (m_rst)         m_flag = 1;
         else if (flag_clr) m_flag = 0;
         m_mode = nm;
         e_f   = (nm <= 1) ? 1'b1 : m_ovr;
         e_h   = (nm == 0) ? 1'b1 : m_ovr;
         e_src = (nm <= 1) ? !m_cfg : 1'b1;
         e_pd  = (nm == 3) && !m_ovr;
      end
   end

   task automatic chk(string nm, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("fclk_en", fclk_en, e_f);
      chk("hclk_en", hclk_en, e_h);
      chk("src_rc", src_rc, e_src);
      chk("sys_clk_en", sys_clk_en, m_cfg);
      chk("pd_req", pd_req, e_pd);
      chk("rst_req", rst_req, m_rst);
      chk("stby_resumed", stby_resumed, m_flag);
   end

   // drive one cycle of inputs at a falling edge
   task automatic drv(input logic [1:0] m, input logic w, input logic [2:0] d,
                      input logic cw, input logic cs, input logic fc, input int n = 1);
      mode_req = m; wake = w; dbg_ctl = d; cfg_wr = cw; cfg_sys = cs; flag_clr = fc;
      repeat (n) @(negedge clk);
   endtask

   task automatic idle(input int n);
      drv(0, 0, 0, 0, 0, 0, n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values while reset is held
      req = "R1";
      chk("fclk_en", fclk_en, 1); chk("hclk_en", hclk_en, 1); chk("src_rc", src_rc, 1);
      chk("sys_clk_en", sys_clk_en, 0); chk("pd_req", pd_req, 0);
      chk("rst_req", rst_req, 0); chk("stby_resumed", stby_resumed, 0);
      rst_n = 1;
      idle(2);
      req = "R7";  drv(0, 1, 0, 0, 0, 0); idle(1);     // wake in run: no effect
      req = "R8";  drv(0, 0, 0, 1, 1, 0); idle(2);     // select system clock
      req = "R3";  drv(1, 0, 3'b000, 0, 0, 0); idle(3); drv(0, 1, 0, 0, 0, 0); idle(1);
      req = "R3";  drv(1, 0, 3'b001, 0, 0, 0); idle(3);
      req = "R8";  drv(0, 0, 0, 1, 0, 0); idle(1);     // cfg_wr in sleep ignored
      drv(0, 1, 0, 0, 0, 0); idle(2);                  // sleep exit keeps cfg
      req = "R6";  drv(2, 0, 3'b010, 0, 0, 0); drv(0, 0, 3'b000, 0, 0, 0, 3);
      req = "R2";  drv(3, 0, 3'b100, 0, 0, 0, 2); drv(1, 0, 0, 0, 0, 0, 2);
      req = "R9";  drv(0, 1, 0, 1, 1, 0); idle(2);     // wake+cfg_wr same edge
      req = "R2";  drv(2, 1, 3'b000, 0, 0, 0); idle(1); // request wins over wake in run
      req = "R4";  idle(3); drv(0, 1, 0, 0, 0, 0); idle(1);
      req = "R8";  drv(0, 0, 0, 1, 1, 0); idle(1);
      req = "R5";  drv(3, 0, 3'b000, 0, 0, 0); idle(3);
      req = "R10"; drv(0, 1, 0, 0, 0, 1); idle(3);     // set beats clear
      req = "R10"; drv(0, 0, 0, 0, 0, 1); idle(2);
      req = "R5";  drv(0, 0, 0, 1, 1, 0); drv(3, 0, 3'b111, 0, 0, 0); drv(0, 0, 3'b000, 0, 0, 0, 3);
      req = "R9";  drv(0, 1, 0, 0, 0, 0); idle(3);
      req = "R6";  drv(1, 0, 3'b110, 0, 0, 0); drv(0, 0, 3'b111, 0, 0, 0, 2);
      drv(0, 1, 0, 0, 0, 0); idle(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule